// File: doc/BRIEF.md
# Mapped Multi-Core Interrupt Router

This block collects 32 level-sensitive interrupt requests and spreads them over a grid of 4 cores by 4 interrupt lines, so there are 16 level outputs in all. Each request has its own one-byte route setting. The low nibble of that byte names the target cores, and the high nibble names the target lines. A 32-bit enable mask gates the requests before they are routed. Software changes the mask through separate set and clear aliases, so it never needs a read-modify-write. Software can read a global status word and one status word per core.

Nothing in the block is latched. Status is always the synchronized pin levels ANDed with the mask. An output for core c and line l is high whenever core c has any pending routed request and line l has any pending routed request, even when those are two different requests. Register access uses separate read and write strobes and a size flag (byte or word). It has no ready handshake, and read data comes back one cycle after the read strobe.

Top module: `irq_route_hub`

## Requirements
- R1: After reset, every route byte and the enable mask are zero, `irq_out` is all zero and `rdata` is zero.
- R2: A word read at 0x20 returns the synchronized pin levels ANDed with the enable mask. It follows the pins (level, not latched), so when a pin falls its bit clears.
- R3: A word read at 0x24 returns the enable mask. A word write at 0x28 ORs the data into the mask, and a word write at 0x2C clears each mask bit where the data has a one. Word reads at 0x28 and 0x2C return zero.
- R4: Byte accesses at offsets 0x00 to 0x1F read and write the route byte of input n = offset. In that byte, bits 3:0 select cores 0 to 3 and bits 7:4 select lines 0 to 3. Word accesses in this range read zero and write nothing.
- R5: A word read at 0x40 + 8·c returns, for core c, the enabled pending inputs whose route byte has core bit c set. A word read at 0x44 (within a slot, not a multiple of 8) returns zero.
- R6: Output bit index c·4 + l is high exactly when core c's status is nonzero and some enabled pending input has line bit l set. The core and the line may come from different inputs.
- R7: Outside the route range, byte accesses and word accesses at addresses that are not 4-aligned read zero and change no state.
- R8: A write to a per-core status slot has no effect: a later read returns the value computed from the pins, the mask and the routes.
- R9: A pin change reaches `irq_out` on the third rising edge (two synchronizer stages plus the output register). A register write reaches `irq_out` on the second rising edge. Read data appears after the edge that samples `rd_en` and is zero in cycles with no read.
- R10: Word reads at unmapped aligned offsets (for example 0x30 and 0x60) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Asynchronous level interrupt requests |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| acc_word | input | 1 | Access size: 1 = 32-bit word, 0 = byte |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data (byte writes use bits 7:0) |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_out | output | 16 | Level outputs, bit index core·4 + line |

## Verification
The hardest case to reach from the ports is an output raised by two different inputs: one routed only to a core and the other routed only to a line. No single route byte produces this case. The stimulus table loads two route bytes that split the core and line nibbles between two inputs. Other table rows then mask one of the two inputs, or drop its pin, to show that the output falls when either half disappears. The directed tests also count edges from a pin change and from a route write to the output, to pin down the latency.

// File: rtl/irq_route_pkg.sv
// Shared constants for the interrupt router: default sizes and register offsets.
// Assumes an 8-bit byte-offset address space and at most 8 cores.
package irq_route_pkg;
    localparam int DEF_NIRQ   = 32;
    localparam int DEF_NCORE  = 4;
    localparam int DEF_NLINE  = 4;
    localparam int DEF_ADDR_W = 8;
    localparam int DEF_DATA_W = 32;

    localparam int OFS_GSTAT   = 'h20;
    localparam int OFS_MASK    = 'h24;
    localparam int OFS_SET     = 'h28;
    localparam int OFS_CLR     = 'h2C;
    localparam int OFS_PCORE   = 'h40;
    localparam int PCORE_STEP  = 8;
endpackage

// File: rtl/irq_sync.sv
// Two-flop synchronizer for a vector of asynchronous level inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Capture the pins, then retime once more into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/irq_route_regs.sv
// Holds the per-input route bytes and the enable mask, and decodes writes.
// Assumes route bytes are written only by byte accesses and the mask only by
// aligned word accesses to the set/clear aliases; everything else is dropped.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NIRQ   = DEF_NIRQ,
    parameter int NCORE  = DEF_NCORE,
    parameter int NLINE  = DEF_NLINE,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int RB    = NCORE + NLINE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     acc_word,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [NIRQ-1:0][RB-1:0]  route,
    output logic [NIRQ-1:0]          ien
);
    logic word_ok;
    assign word_ok = acc_word && (addr[1:0] == 2'b00);

    // Byte writes in the route range update one route byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route <= '0;
        end else if (wr_en && !acc_word) begin
            for (int i = 0; i < NIRQ; i++) begin
                if (addr == ADDR_W'(i)) route[i] <= wdata[RB-1:0];
            end
        end
    end

    // Aligned word writes to the aliases set or clear mask bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= '0;
        end else if (wr_en && word_ok) begin
            if (addr == ADDR_W'(OFS_SET))      ien <= ien | wdata[NIRQ-1:0];
            else if (addr == ADDR_W'(OFS_CLR)) ien <= ien & ~wdata[NIRQ-1:0];
        end
    end

    AST_BYTE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc_word) |=> $stable(ien)); // R7
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_word && addr == ADDR_W'(OFS_SET))
        |=> ((ien & $past(wdata[NIRQ-1:0])) == $past(wdata[NIRQ-1:0]))); // R3
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_word && addr == ADDR_W'(OFS_CLR))
        |=> ((ien & $past(wdata[NIRQ-1:0])) == '0)); // R3
    AST_WORD_KEEPS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_word) |=> $stable(route)); // R4
endmodule

// File: rtl/irq_route_core.sv
// Masks the synchronized levels, builds global and per-core status, and
// drives the registered core x line output grid.
// Assumes route byte bits [NCORE-1:0] pick cores and the upper bits pick lines.
module irq_route_core #(
    parameter int NIRQ  = 32,
    parameter int NCORE = 4,
    parameter int NLINE = 4,
    localparam int RB   = NCORE + NLINE,
    localparam int NOUT = NCORE * NLINE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NIRQ-1:0]            pins,
    input  logic [NIRQ-1:0]            ien,
    input  logic [NIRQ-1:0][RB-1:0]    route,
    output logic [NIRQ-1:0]            gstat,
    output logic [NCORE-1:0][NIRQ-1:0] core_stat,
    output logic [NOUT-1:0]            irq_out
);
    logic [NLINE-1:0] line_any;
    logic [NOUT-1:0]  out_d;

    assign gstat = pins & ien;

    // Split the pending set by core bit and OR it by line bit.
    always_comb begin
        line_any  = '0;
        core_stat = '0;
        for (int i = 0; i < NIRQ; i++) begin
            for (int c = 0; c < NCORE; c++)
                core_stat[c][i] = gstat[i] & route[i][c];
            for (int l = 0; l < NLINE; l++)
                line_any[l] = line_any[l] | (gstat[i] & route[i][NCORE+l]);
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        for (genvar l = 0; l < NLINE; l++) begin : g_line
            assign out_d[c*NLINE+l] = (|core_stat[c]) & line_any[l];

            AST_OUT_NEEDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
                irq_out[c*NLINE+l] |-> $past(|core_stat[c])); // R6
        end
        AST_PCORE_IN_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
            (core_stat[c] & ~gstat) == '0); // R5
    end

    // Register the grid so outputs change only on clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= out_d;
    end
endmodule

// File: rtl/irq_route_hub.sv
// Top of the interrupt router: synchronizer, register file, routing core and
// the registered read-data mux.
// Assumes no ready handshake: one access per strobe, read data the next cycle.
module irq_route_hub
    import irq_route_pkg::*;
#(
    parameter int NIRQ   = DEF_NIRQ,
    parameter int NCORE  = DEF_NCORE,
    parameter int NLINE  = DEF_NLINE,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int RB    = NCORE + NLINE,
    localparam int NOUT  = NCORE * NLINE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIRQ-1:0]   irq_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              acc_word,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NOUT-1:0]   irq_out
);
    logic [NIRQ-1:0]            pins;
    logic [NIRQ-1:0][RB-1:0]    route;
    logic [NIRQ-1:0]            ien;
    logic [NIRQ-1:0]            gstat;
    logic [NCORE-1:0][NIRQ-1:0] core_stat;
    logic [DATA_W-1:0]          rd_val;

    irq_sync #(.W(NIRQ)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(irq_in), .q(pins)
    );

    irq_route_regs #(.NIRQ(NIRQ), .NCORE(NCORE), .NLINE(NLINE),
                     .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_word(acc_word),
        .addr(addr), .wdata(wdata), .route(route), .ien(ien)
    );

    irq_route_core #(.NIRQ(NIRQ), .NCORE(NCORE), .NLINE(NLINE)) core_i (
        .clk(clk), .rst_n(rst_n), .pins(pins), .ien(ien), .route(route),
        .gstat(gstat), .core_stat(core_stat), .irq_out(irq_out)
    );

    // Select the read value by size, alignment and offset.
    always_comb begin
        rd_val = '0;
        if (!acc_word) begin
            for (int i = 0; i < NIRQ; i++)
                if (addr == ADDR_W'(i)) rd_val = DATA_W'(route[i]);
        end else if (addr[1:0] == 2'b00) begin
            if (addr == ADDR_W'(OFS_GSTAT)) rd_val = DATA_W'(gstat);
            if (addr == ADDR_W'(OFS_MASK))  rd_val = DATA_W'(ien);
            for (int c = 0; c < NCORE; c++)
                if (addr == ADDR_W'(OFS_PCORE + c*PCORE_STEP))
                    rd_val = DATA_W'(core_stat[c]);
        end
    end

    // Return read data one cycle after the strobe, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
        else            rdata <= '0;
    end

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0)); // R9
    AST_GSTAT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc_word && addr == ADDR_W'(OFS_GSTAT))
        |=> ((rdata[NIRQ-1:0] & ~$past(ien)) == '0)); // R2
endmodule

// File: tb/irq_route_hub_tb.sv
`timescale 1ns/1ps
module irq_route_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, acc_word = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] irq_out;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    irq_route_hub dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .acc_word(acc_word), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    // {route0, route1, pins, mask, expected irq_out}
    localparam int NV = 8;
    localparam logic [95:0] VEC [NV] = '{
        {8'h11, 8'h00, 32'h1, 32'h1, 16'h0001},
        {8'h11, 8'h00, 32'h1, 32'h0, 16'h0000},
        {8'h01, 8'h20, 32'h3, 32'h3, 16'h0002},
        {8'hF8, 8'h00, 32'h1, 32'h1, 16'hF000},
        {8'h33, 8'h84, 32'h3, 32'h3, 16'h0BBB},
        {8'h33, 8'h84, 32'h2, 32'h3, 16'h0800},
        {8'h33, 8'h84, 32'h3, 32'h1, 16'h0033},
        {8'h0F, 8'h00, 32'h1, 32'h1, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic word, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; acc_word = word; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic word, input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; acc_word = word; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq_out", 32'(irq_out), 32'h0);
        chk("R1 rdata", rdata, 32'h0);
        rd(1'b1, 8'h24, v); chk("R1 mask", v, 32'h0);
        rd(1'b0, 8'h00, v); chk("R1 route0", v, 32'h0);

        // R6: table of route/pin/mask patterns
        for (int k = 0; k < NV; k++) begin
            wr(1'b0, 8'h00, {24'h0, VEC[k][95:88]});
            wr(1'b0, 8'h01, {24'h0, VEC[k][87:80]});
            wr(1'b1, 8'h2C, 32'hFFFF_FFFF);
            wr(1'b1, 8'h28, VEC[k][47:16]);
            @(negedge clk); irq_in = VEC[k][79:48];
            settle();
            chk($sformatf("R6 vector %0d", k), 32'(irq_out), 32'(VEC[k][15:0]));
        end
        wr(1'b0, 8'h00, 32'h0); wr(1'b0, 8'h01, 32'h0);
        wr(1'b1, 8'h2C, 32'hFFFF_FFFF);
        @(negedge clk); irq_in = '0;
        settle();

        // R2: global status is masked level
        wr(1'b1, 8'h28, 32'h0000_0105);
        @(negedge clk); irq_in = 32'h0000_000D;
        settle();
        rd(1'b1, 8'h20, v); chk("R2 status", v, 32'h0000_0005);
        @(negedge clk); irq_in = 32'h0;
        settle();
        rd(1'b1, 8'h20, v); chk("R2 level drop", v, 32'h0);

        // R3: set/clear aliases
        wr(1'b1, 8'h2C, 32'hFFFF_FFFF);
        wr(1'b1, 8'h28, 32'h0000_000F);
        wr(1'b1, 8'h2C, 32'h0000_0005);
        rd(1'b1, 8'h24, v); chk("R3 mask", v, 32'h0000_000A);
        rd(1'b1, 8'h28, v); chk("R3 set alias read", v, 32'h0);
        rd(1'b1, 8'h2C, v); chk("R3 clr alias read", v, 32'h0);

        // R4: route byte access
        wr(1'b0, 8'h1F, 32'h0000_00A5);
        rd(1'b0, 8'h1F, v); chk("R4 route31", v, 32'h0000_00A5);
        wr(1'b1, 8'h04, 32'hFFFF_FFFF);
        rd(1'b0, 8'h04, v); chk("R4 word write ignored", v, 32'h0);
        rd(1'b1, 8'h1C, v); chk("R4 word read zero", v, 32'h0);
        wr(1'b0, 8'h1F, 32'h0);

        // R5: per-core status
        wr(1'b0, 8'h05, 32'h0000_0024);
        wr(1'b0, 8'h06, 32'h0000_0011);
        wr(1'b1, 8'h28, 32'hFFFF_FFFF);
        @(negedge clk); irq_in = 32'h0000_0060;
        settle();
        rd(1'b1, 8'h50, v); chk("R5 core2", v, 32'h0000_0020);
        rd(1'b1, 8'h40, v); chk("R5 core0", v, 32'h0000_0040);
        rd(1'b1, 8'h44, v); chk("R5 mid-slot", v, 32'h0);

        // R8: per-core slot write has no effect
        wr(1'b1, 8'h40, 32'h0);
        rd(1'b1, 8'h40, v); chk("R8 core0 after write", v, 32'h0000_0040);

        // R7: byte / unaligned accesses outside route range
        wr(1'b0, 8'h2C, 32'h0000_00FF);
        rd(1'b1, 8'h24, v); chk("R7 byte clr ignored", v, 32'hFFFF_FFFF);
        wr(1'b1, 8'h2D, 32'hFFFF_FFFF);
        rd(1'b1, 8'h24, v); chk("R7 unaligned clr ignored", v, 32'hFFFF_FFFF);
        rd(1'b0, 8'h24, v); chk("R7 byte read zero", v, 32'h0);
        rd(1'b1, 8'h25, v); chk("R7 unaligned read zero", v, 32'h0);

        // R10: unmapped reads
        rd(1'b1, 8'h30, v); chk("R10 0x30", v, 32'h0);
        rd(1'b1, 8'h60, v); chk("R10 0x60", v, 32'h0);

        // R9: pin-to-output latency (core2 line1 = bit 9 from input 5)
        @(negedge clk); irq_in = 32'h0;
        settle();
        chk("R9 quiet", 32'(irq_out), 32'h0);
        @(negedge clk); irq_in = 32'h0000_0020;
        @(negedge clk);
        @(negedge clk);
        chk("R9 after two edges", 32'(irq_out), 32'h0);
        @(negedge clk);
        chk("R9 after three edges", 32'(irq_out), 32'h0000_0200);

        // R9: write-to-output latency (input 5 rerouted to core0 line0)
        wr(1'b0, 8'h05, 32'h0000_0011);
        chk("R9 write one edge", 32'(irq_out), 32'h0000_0200);
        @(negedge clk);
        chk("R9 write two edges", 32'(irq_out), 32'h0000_0001);

        finish_run();
    end
endmodule